// File: doc/BRIEF.md
# Pipelined Tree Priority Encoder

This block finds the lowest-numbered set bit of a wide request vector and reports its index in binary, with a flag that tells an empty vector apart from a request on bit 0. The search runs in a tree of small base encoders. The first layer splits the request vector into slices of `BASE` bits. Each later layer treats the hit flags of the layer below it as its own request bits. At each layer, the winning child's partial index is selected by a multiplexer steered by the parent's local index. That partial index becomes the low-order part of the parent's index. The final index is therefore assembled from the top of the tree down.

Two parameters pick the variant. `PIPE` places a register on the outputs of every layer, or leaves the tree combinational. `PREFIX` builds each base encoder either as a plain scan or as a prefix-OR thermometer followed by edge detection. The layer registers clear asynchronously while `rst_ni` is low. They share a single advance input, `adv_i`. This is the only back-pressure rule: while `adv_i` is low, every stage holds its contents and new requests are not taken in. When `adv_i` returns high, the held items move on in their original order and none is lost. When `WIDTH` is not a multiple of `BASE`, the unused inputs of the last slice read as zero.

Top module: `prio_tree`

## Requirements
- R1: When `found_o` is 1, `idx_o` is the position of the lowest set bit of the request vector it answers; lower positions win over higher ones.
- R2: `found_o` is 1 exactly when the answered request vector has at least one bit set; when it is 0, `idx_o` is 0.
- R3: With `PIPE`=1, a request sampled on an edge with `adv_i` high appears at the outputs after L advancing edges, where L is the number of tree layers (smallest L with `BASE`^L >= `WIDTH`; 3 for the default 50/4). With `PIPE`=0, the outputs follow `req_i` in the same cycle.
- R4: With `PIPE`=1, while `adv_i` is low the outputs stay unchanged and `req_i` is ignored; after `adv_i` rises again, the stalled items emerge in order with none dropped or repeated.
- R5: While `rst_ni` is low, every layer register is cleared, so `found_o`=0 and `idx_o`=0, without waiting for a clock edge.
- R6: The plain-scan base encoder (`PREFIX`=0) and the prefix-OR base encoder (`PREFIX`=1) produce identical outputs for identical input sequences.
- R7: When `WIDTH` is not a multiple of `BASE`, the padded slice still resolves correctly, including a request on bit `WIDTH`-1 alone.
- R8: `idx_o` never exceeds `WIDTH`-1 while `found_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the layer registers |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adv_i | input | 1 | Active-high advance; low stalls every stage |
| req_i | input | WIDTH | Request bits, bit 0 has the highest priority |
| idx_o | output | clog2(WIDTH) | Binary index of the winning request |
| found_o | output | 1 | At least one request bit was set |

## Verification
The bench walks a single request across every position, including the top bit of the padded slice. If a slice were misaligned or the pad were wrong, that sweep would report a wrong index. A mux steered by the wrong layer's index would also show up in the sweep. Dense random vectors test priority between siblings and cousins in the tree; a design that let a higher bit win would fail there. A lone pulse sent through an empty pipeline measures the latency, which catches a missing or extra register stage. Random stalls mixed with changing requests would expose a stage that ignores `adv_i`, since it would drop or duplicate items. A mid-stream reset shows whether any stage failed to clear.

// File: rtl/prio_pkg.sv
package prio_pkg;

  function automatic int lg2c(input int v);
    int r;
    r = 0;
    while ((1 << r) < v) r++;
    return (r == 0) ? 1 : r;
  endfunction

  function automatic int tree_layers(input int w, input int b);
    int     l;
    longint p;
    l = 1;
    p = b;
    while (p < w) begin
      p = p * b;
      l++;
    end
    return l;
  endfunction

  function automatic int layer_nodes(input int w, input int b, input int k);
    longint p;
    p = b;
    for (int i = 0; i < k; i++) p = p * b;
    return int'((w + p - 1) / p);
  endfunction

endpackage

// File: rtl/pe_base.sv
module pe_base
  import prio_pkg::*;
#(
  parameter int B      = 4,
  parameter int PREFIX = 1,
  parameter int LB     = lg2c(B)
) (
  input  logic [B-1:0]  r,
  output logic [LB-1:0] idx,
  output logic          hit
);

  if (PREFIX != 0) begin : g_prefix
    logic [B-1:0] th;
    logic [B-1:0] oh;
    always_comb begin
      th = r;
      for (int s = 1; s < B; s = s * 2) th = th | (th << s);
      oh = th & ~(th << 1);
      idx = '0;
      for (int i = 0; i < B; i++)
        if (oh[i]) idx = idx | LB'(i);
    end
    assign hit = th[B-1];
  end else begin : g_scan
    always_comb begin
      idx = '0;
      hit = 1'b0;
      for (int i = B - 1; i >= 0; i--)
        if (r[i]) begin
          idx = LB'(i);
          hit = 1'b1;
        end
    end
  end

endmodule

// File: rtl/pe_layer.sv
module pe_layer
  import prio_pkg::*;
#(
  parameter int B      = 4,
  parameter int NK     = 1,
  parameter int PWI    = 0,
  parameter int PIPE   = 1,
  parameter int PREFIX = 1,
  parameter int LB     = lg2c(B),
  parameter int PWC    = (PWI > 0) ? PWI : 1,
  parameter int PWO    = PWI + LB
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic [NK*B-1:0]       rq,
  input  logic [NK*B*PWC-1:0]   sub,
  output logic [NK-1:0]         hit_o,
  output logic [NK*PWO-1:0]     part_o
);

  logic [NK-1:0]     hc;
  logic [NK*PWO-1:0] pcomb;

  for (genvar n = 0; n < NK; n++) begin : g_node
    logic [LB-1:0] li;
    pe_base #(.B(B), .PREFIX(PREFIX), .LB(LB)) u_b (
      .r   (rq[n*B +: B]),
      .idx (li),
      .hit (hc[n])
    );
    if (PWI == 0) begin : g_leaf
      assign pcomb[n*PWO +: PWO] = li;
    end else begin : g_mux
      always_comb begin
        int sel;
        sel = n * B + int'(li);
        pcomb[n*PWO +: PWO] = {li, sub[sel*PWC +: PWC]};
      end
    end
  end

  if (PWI == 0) begin : g_nosub
    logic unused_sub;
    assign unused_sub = ^sub;
  end

  if (PIPE != 0) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hit_o  <= '0;
        part_o <= '0;
      end else if (en) begin
        hit_o  <= hc;
        part_o <= pcomb;
      end
    end
  end else begin : g_comb
    logic unused_ctl;
    assign unused_ctl = clk ^ rst_n ^ en;
    assign hit_o  = hc;
    assign part_o = pcomb;
  end

endmodule

// File: rtl/prio_tree.sv
module prio_tree
  import prio_pkg::*;
#(
  parameter int WIDTH  = 50,
  parameter int BASE   = 4,
  parameter int PREFIX = 1,
  parameter int PIPE   = 1,
  parameter int OW     = lg2c(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic [WIDTH-1:0] req_i,
  output logic [OW-1:0]    idx_o,
  output logic             found_o
);

  localparam int LB    = lg2c(BASE);
  localparam int NL    = tree_layers(WIDTH, BASE);
  localparam int NMAX  = layer_nodes(WIDTH, BASE, 0);
  localparam int PWMAX = NL * LB;
  localparam int PMAX  = NMAX * PWMAX;

  logic [NMAX-1:0] hit_all  [NL];
  logic [PMAX-1:0] part_all [NL];

  for (genvar k = 0; k < NL; k++) begin : g_lay
    localparam int NK  = layer_nodes(WIDTH, BASE, k);
    localparam int PWI = k * LB;
    localparam int PWC = (PWI > 0) ? PWI : 1;
    localparam int NIN = NK * BASE;
    localparam int SW  = NIN * PWC;
    localparam int PWO = PWI + LB;

    logic [NIN-1:0]    rin;
    logic [SW-1:0]     sin;
    logic [NK-1:0]     hit;
    logic [NK*PWO-1:0] part;

    if (k == 0) begin : g_first
      assign rin = NIN'(req_i);
      assign sin = '0;
    end else begin : g_next
      assign rin = NIN'(hit_all[k-1]);
      assign sin = SW'(part_all[k-1]);
    end

    pe_layer #(
      .B(BASE), .NK(NK), .PWI(PWI), .PIPE(PIPE), .PREFIX(PREFIX)
    ) u_layer (
      .clk    (clk_i),
      .rst_n  (rst_ni),
      .en     (adv_i),
      .rq     (rin),
      .sub    (sin),
      .hit_o  (hit),
      .part_o (part)
    );

    assign hit_all[k]  = NMAX'(hit);
    assign part_all[k] = PMAX'(part);
  end

  assign found_o = hit_all[NL-1][0];
  assign idx_o   = part_all[NL-1][OW-1:0];

  logic unused_tail;
  assign unused_tail = ^{hit_all[NL-1], part_all[NL-1]};

endmodule

// File: rtl/prio_tree_chk.sv
module prio_tree_chk #(
  parameter int WIDTH = 50,
  parameter int PIPE  = 1,
  parameter int OW    = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [WIDTH-1:0] req,
  input logic [OW-1:0]    idx,
  input logic             found
);

  logic unused_in;
  assign unused_in = ^{req, en};

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !found |-> (idx == '0)); // R2

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (int'(idx) < WIDTH)); // R8

  if (PIPE != 0) begin : g_pipe_chk
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ($stable(idx) && $stable(found))); // R4
  end else begin : g_comb_chk
    AST_COMB_FOUND: assert property (@(posedge clk) disable iff (!rst_n)
      found == (|req)); // R2
    AST_COMB_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> (req[idx] && ((req & ((WIDTH'(1) << idx) - WIDTH'(1))) == '0))); // R1
  end

endmodule

bind prio_tree prio_tree_chk #(.WIDTH(WIDTH), .PIPE(PIPE), .OW(OW)) u_chk (
  .clk   (clk_i),
  .rst_n (rst_ni),
  .en    (adv_i),
  .req   (req_i),
  .idx   (idx_o),
  .found (found_o)
);

// File: tb/sim_prio_tree.sv
`timescale 1ns/1ps
module sim_prio_tree;

  localparam int W  = 50;
  localparam int B  = 4;
  localparam int OW = 6;

  function automatic int calc_layers();
    int l;
    int p;
    l = 1;
    p = B;
    while (p < W) begin
      p = p * B;
      l++;
    end
    return l;
  endfunction

  localparam int NL = calc_layers();

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b1;
  logic [W-1:0]  req = '0;
  logic [OW-1:0] idx0, idx1, idx2;
  logic          f0, f1, f2;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  prio_tree #(.WIDTH(W), .BASE(B), .PREFIX(1), .PIPE(1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .adv_i(en), .req_i(req), .idx_o(idx0), .found_o(f0));
  prio_tree #(.WIDTH(W), .BASE(B), .PREFIX(1), .PIPE(0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .adv_i(en), .req_i(req), .idx_o(idx1), .found_o(f1));
  prio_tree #(.WIDTH(W), .BASE(B), .PREFIX(0), .PIPE(1)) u2 (
    .clk_i(clk), .rst_ni(rst_n), .adv_i(en), .req_i(req), .idx_o(idx2), .found_o(f2));

  function automatic logic [OW:0] ref_enc(input logic [W-1:0] r);
    for (int i = 0; i < W; i++)
      if (r[i]) return {1'b1, OW'(i)};
    return '0;
  endfunction

  logic [OW:0] mp [NL];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NL; i++) mp[i] <= '0;
    end else if (en) begin
      mp[0] <= ref_enc(req);
      for (int i = 1; i < NL; i++) mp[i] <= mp[i-1];
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    logic [OW:0] e1;
    e1 = ref_enc(req);
    chk({f0, idx0} == mp[NL-1], {tag, " R1 R3 pipelined prefix"}, int'({f0, idx0}), int'(mp[NL-1]));
    chk({f1, idx1} == e1, {tag, " R1 R2 combinational"}, int'({f1, idx1}), int'(e1));
    chk({f2, idx2} == mp[NL-1], {tag, " R6 pipelined scan"}, int'({f2, idx2}), int'(mp[NL-1]));
  endtask

  task automatic cyc(input logic [W-1:0] r, input logic e, input string tag);
    @(negedge clk);
    compare_all(tag);
    req = r;
    en  = e;
  endtask

  function automatic logic [W-1:0] rnd_vec(input int density);
    logic [W-1:0] v;
    v = {$urandom, $urandom};
    for (int d = 0; d < density; d++) v = v & {$urandom, $urandom};
    return v;
  endfunction

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R5: outputs cleared during reset
    chk(!f0 && idx0 == '0, "R5 reset u0", int'({f0, idx0}), 0);
    chk(!f2 && idx2 == '0, "R5 reset u2", int'({f2, idx2}), 0);
    rst_n = 1'b1;

    // R2: empty vector
    for (int i = 0; i < NL + 2; i++) cyc('0, 1'b1, "R2 empty");

    // R1 R7: single bit walk including the padded slice's top bit
    for (int i = 0; i < W; i++) cyc(W'(1) << i, 1'b1, "R7 walk");
    cyc({1'b1, {(W-1){1'b0}}}, 1'b1, "R7 top bit");
    cyc('1, 1'b1, "R1 all ones");
    cyc({W{1'b1}} << 37, 1'b1, "R1 upper half");
    for (int i = 0; i < NL + 1; i++) cyc('0, 1'b1, "R2 drain");

    // R3: latency of a lone pulse
    begin
      int lat;
      lat = -1;
      @(negedge clk);
      req = W'(1) << 21;
      en  = 1'b1;
      for (int c = 1; c <= NL + 3; c++) begin
        @(negedge clk);
        req = '0;
        if (f0 && lat < 0) lat = c;
      end
      chk(lat == NL, "R3 latency", lat, NL);
      chk(idx0 == '0 && !f0, "R3 pulse drained", int'({f0, idx0}), 0);
    end

    // R4: stall with changing requests, then resume
    for (int i = 0; i < NL; i++) cyc(W'(3) << (5 * i + 1), 1'b1, "R4 fill");
    begin
      logic [OW:0] held;
      @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      held = {f0, idx0};
      for (int i = 0; i < 5; i++) begin
        req = rnd_vec(1);
        @(negedge clk);
        chk({f0, idx0} == held, "R4 stalled output held", int'({f0, idx0}), int'(held));
      end
    end
    for (int i = 0; i < NL + 2; i++) cyc(rnd_vec(2), 1'b1, "R4 resume");

    // R1 R2 R4 R6 R8: random traffic with random stalls
    for (int n = 0; n < 3000; n++)
      cyc(rnd_vec($urandom_range(0, 4)), ($urandom_range(0, 3) != 0), "random");

    // R5: asynchronous reset mid-stream
    for (int i = 0; i < NL; i++) cyc('1, 1'b1, "R5 load");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!f0 && idx0 == '0, "R5 async clear u0", int'({f0, idx0}), 0);
    chk(!f2 && idx2 == '0, "R5 async clear u2", int'({f2, idx2}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NL + 2; i++) cyc(rnd_vec(1), 1'b1, "R5 after reset");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule